// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Status Reporting

This block turns an asynchronous serial input into received words. A tick from a shared baud generator paces it at sixteen ticks per bit. A line-control input sets the framing: the word length, whether a parity bit is present and how it is computed, and whether a second stop bit is checked. Each completed word goes into a single holding register. A line status byte reports data-ready, overrun, parity, framing and break conditions, plus a sticky summary of the error bits.

The host takes a word with a data-read strobe and clears the error bits with a status-read strobe. When an error bit newly sets, or when a delta bit in the modem status input rises, the block sends a two-byte status report on a strobe. The modem status byte comes first and the line status byte second.

Framer states: `FR_IDLE` goes to `FR_START` on a tick that sees the line low. `FR_START` returns to `FR_IDLE` if the line is high at mid-bit (false start), and otherwise goes to `FR_DATA`. `FR_DATA` goes to `FR_PARITY` after the last data bit when parity is enabled, and to `FR_STOP` when it is not. `FR_PARITY` goes to `FR_STOP`. `FR_STOP` goes to `FR_BRKWAIT` on a break, to `FR_STOP2` when a second stop bit must be checked, and otherwise to `FR_IDLE`. `FR_STOP2` goes to `FR_IDLE`. `FR_BRKWAIT` goes to `FR_IDLE` on a tick that sees the line high.

Report states: `RP_IDLE` goes to `RP_MODEM` on a trigger. `RP_MODEM` goes to `RP_LINE`. `RP_LINE` goes back to `RP_MODEM` if another trigger is pending or arrives, and otherwise to `RP_IDLE`.

Top module: `rx_line_top`

## Requirements
- R1: After reset, `rx_data` is 0x00, `lsr` is 0x00 and `rpt_valid` is low.
- R2: The word length is 5 + `lcr[1:0]` bits. Data arrives least significant bit first, each bit sampled at its centre. Unused upper bits of `rx_data` read 0.
- R3: `lsr[0]` (data ready) sets only when a finished word has been written into the holding register. A `rd_data` pulse clears it.
- R4: If a word finishes while `lsr[0]` is set and no `rd_data` pulse comes in the same cycle, `lsr[1]` (overrun) sets. That word is dropped and `rx_data` keeps the older word.
- R5: With `lcr[3]` set, a parity bit follows the data. If `lcr[5]` is set, that bit must equal NOT `lcr[4]`. Otherwise it gives even parity when `lcr[4]` is 1 and odd parity when `lcr[4]` is 0. A mismatch sets `lsr[2]`.
- R6: A 0 in the first stop bit sets `lsr[3]`. When `lcr[2]` is set and the word length is 6 bits or more, a 0 in the second stop bit also sets `lsr[3]`.
- R7: A frame that is 0 in every bit, stop bit included, stores one word of 0x00 and sets `lsr[4]` and `lsr[3]`. No further word is taken until the line goes high again.
- R8: `lsr[7]` sets whenever a stored word sets `lsr[2]`, `lsr[3]` or `lsr[4]`. Bits 6 and 5 read 0.
- R9: A `rd_status` pulse clears `lsr[4:1]` and `lsr[7]` and leaves `lsr[0]` as it was.
- R10: When a bit of `lsr[4:1]` goes from clear to set, or a bit of `msr[3:0]` rises, the block sends a report. The report is two consecutive cycles with `rpt_valid` high: the first has `rpt_sel`=0 and `rpt_byte`=`msr`, the second has `rpt_sel`=1 and `rpt_byte`=`lsr`.
- R11: A low pulse that has ended by mid-bit of the start bit is ignored. No word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line, idle high |
| lcr | input | 6 | Framing: [1:0] length, [2] two stops, [3] parity on, [4] even, [5] stick |
| os_tick | input | 1 | Oversampling tick, 16 per bit |
| rd_data | input | 1 | Host takes the held word |
| rd_status | input | 1 | Host takes the line status |
| msr | input | 8 | Modem status byte, [3:0] are delta bits |
| rx_data | output | 8 | Holding register |
| lsr | output | 8 | Line status byte |
| rpt_valid | output | 1 | Report byte valid |
| rpt_sel | output | 1 | 0 = modem byte, 1 = line byte |
| rpt_byte | output | 8 | Report byte |

## Verification
The receiver is driven with clean frames in 8-bit no-parity, 7-bit even, 8-bit odd, mark and space stick parity, 5-bit, and 8-bit two-stop formats. These separate the word-length masking from the parity computations. A corrupted parity bit, a low first or second stop bit, a long low line, two unread words in a row and a short low glitch then each provoke exactly one status condition, so the bits of the status byte can be told apart. A rising modem delta bit with no line error shows that the report fires on modem changes alone and carries the current line status.

// File: rtl/rxls_pkg.sv
package rxls_pkg;

    localparam int DATA_W = 8;

    localparam int LSR_DR  = 0;
    localparam int LSR_OE  = 1;
    localparam int LSR_PE  = 2;
    localparam int LSR_FE  = 3;
    localparam int LSR_BI  = 4;
    localparam int LSR_ERR = 7;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PARITY,
        FR_STOP,
        FR_STOP2,
        FR_BRKWAIT
    } fr_state_t;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_MODEM,
        RP_LINE
    } rp_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_word_t;

endpackage

// File: rtl/rx_framer.sv
module rx_framer
    import rxls_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [5:0] lcr,
    output logic       word_done,
    output rx_word_t   word
);
    localparam int CW        = $clog2(OSR);
    localparam int IW        = $clog2(DATA_W);
    localparam int MID_LAST  = OSR / 2 - 1;
    localparam int FULL_LAST = OSR - 1;

    fr_state_t         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic              zero_q;

    logic          mid_hit, bit_hit;
    logic [IW-1:0] last_idx;
    logic          pen, eps, stick, two_stop;
    logic          dpar, exp_par, is_break;

    assign mid_hit  = tick && (cnt_q == CW'(MID_LAST));
    assign bit_hit  = tick && (cnt_q == CW'(FULL_LAST));
    assign last_idx = IW'(4) + IW'(lcr[1:0]);
    assign pen      = lcr[3];
    assign eps      = lcr[4];
    assign stick    = lcr[5];
    assign two_stop = lcr[2] && (lcr[1:0] != 2'b00);
    assign dpar     = ^shreg_q;
    assign exp_par  = stick ? ~eps : (eps ? dpar : ~dpar);
    assign is_break = zero_q && !rxd;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:    if (tick && !rxd) state_d = FR_START;
            FR_START:   if (mid_hit) state_d = rxd ? FR_IDLE : FR_DATA;
            FR_DATA:    if (bit_hit && idx_q == last_idx)
                            state_d = pen ? FR_PARITY : FR_STOP;
            FR_PARITY:  if (bit_hit) state_d = FR_STOP;
            FR_STOP: begin
                if (bit_hit) begin
                    if (is_break)             state_d = FR_BRKWAIT;
                    else if (rxd && two_stop) state_d = FR_STOP2;
                    else                      state_d = FR_IDLE;
                end
            end
            FR_STOP2:   if (bit_hit) state_d = FR_IDLE;
            FR_BRKWAIT: if (tick && rxd) state_d = FR_IDLE;
            default:    state_d = FR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            par_q     <= 1'b0;
            zero_q    <= 1'b0;
            word_done <= 1'b0;
            word      <= '0;
        end else begin
            word_done <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    FR_IDLE: cnt_q <= '0;
                    FR_START: begin
                        if (cnt_q == CW'(MID_LAST)) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            shreg_q <= '0;
                            par_q   <= 1'b0;
                            zero_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_DATA: begin
                        if (cnt_q == CW'(FULL_LAST)) begin
                            cnt_q          <= '0;
                            shreg_q[idx_q] <= rxd;
                            zero_q         <= zero_q & ~rxd;
                            idx_q          <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_PARITY: begin
                        if (cnt_q == CW'(FULL_LAST)) begin
                            cnt_q  <= '0;
                            par_q  <= rxd;
                            zero_q <= zero_q & ~rxd;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_STOP: begin
                        if (cnt_q == CW'(FULL_LAST)) begin
                            cnt_q      <= '0;
                            word.data  <= shreg_q;
                            word.perr  <= pen && (par_q != exp_par);
                            word.ferr  <= ~rxd;
                            word.brk   <= is_break;
                            word_done  <= !(rxd && two_stop);
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_STOP2: begin
                        if (cnt_q == CW'(FULL_LAST)) begin
                            cnt_q     <= '0;
                            word.ferr <= ~rxd;
                            word_done <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_BRKWAIT: cnt_q <= '0;
                    default:    cnt_q <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/rx_lstat.sv
module rx_lstat
    import rxls_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  rx_word_t          word,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        lsr,
    output logic              err_new
);
    logic dr_q, oe_q, pe_q, fe_q, bi_q, er_q;
    logic full, store, ovr, set_pe, set_fe, set_bi;

    assign full   = dr_q && !rd_data;
    assign store  = word_done && !full;
    assign ovr    = word_done && full;
    assign set_pe = store && word.perr;
    assign set_fe = store && word.ferr;
    assign set_bi = store && word.brk;

    assign err_new = (ovr && !oe_q) || (set_pe && !pe_q) ||
                     (set_fe && !fe_q) || (set_bi && !bi_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            dr_q    <= 1'b0;
            oe_q    <= 1'b0;
            pe_q    <= 1'b0;
            fe_q    <= 1'b0;
            bi_q    <= 1'b0;
            er_q    <= 1'b0;
        end else begin
            if (store) begin
                rx_data <= word.data;
                dr_q    <= 1'b1;
            end else if (rd_data) begin
                dr_q <= 1'b0;
            end
            if (ovr)            oe_q <= 1'b1;
            else if (rd_status) oe_q <= 1'b0;
            if (set_pe)         pe_q <= 1'b1;
            else if (rd_status) pe_q <= 1'b0;
            if (set_fe)         fe_q <= 1'b1;
            else if (rd_status) fe_q <= 1'b0;
            if (set_bi)         bi_q <= 1'b1;
            else if (rd_status) bi_q <= 1'b0;
            if (set_pe || set_fe || set_bi) er_q <= 1'b1;
            else if (rd_status)             er_q <= 1'b0;
        end
    end

    always_comb begin
        lsr          = '0;
        lsr[LSR_DR]  = dr_q;
        lsr[LSR_OE]  = oe_q;
        lsr[LSR_PE]  = pe_q;
        lsr[LSR_FE]  = fe_q;
        lsr[LSR_BI]  = bi_q;
        lsr[LSR_ERR] = er_q;
    end

endmodule

// File: rtl/rx_report.sv
module rx_report
    import rxls_pkg::*;
#(
    parameter int DELTA_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       err_new,
    input  logic [7:0] msr,
    input  logic [7:0] lsr,
    output logic       rpt_valid,
    output logic       rpt_sel,
    output logic [7:0] rpt_byte
);
    rp_state_t          state_q, state_d;
    logic [DELTA_W-1:0] dprev_q;
    logic               pend_q;
    logic               delta_new, trig;

    assign delta_new = |(msr[DELTA_W-1:0] & ~dprev_q);
    assign trig      = err_new || delta_new;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE:  if (trig) state_d = RP_MODEM;
            RP_MODEM: state_d = RP_LINE;
            RP_LINE:  state_d = (pend_q || trig) ? RP_MODEM : RP_IDLE;
            default:  state_d = RP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
            dprev_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            dprev_q <= msr[DELTA_W-1:0];
            if (state_q == RP_MODEM && trig) pend_q <= 1'b1;
            else if (state_q == RP_LINE)     pend_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        rpt_valid = 1'b0;
        rpt_sel   = 1'b0;
        rpt_byte  = 8'h00;
        unique case (state_q)
            RP_MODEM: begin
                rpt_valid = 1'b1;
                rpt_byte  = msr;
            end
            RP_LINE: begin
                rpt_valid = 1'b1;
                rpt_sel   = 1'b1;
                rpt_byte  = lsr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rx_line_top.sv
module rx_line_top
    import rxls_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic [5:0] lcr,
    input  logic       os_tick,
    input  logic       rd_data,
    input  logic       rd_status,
    input  logic [7:0] msr,
    output logic [7:0] rx_data,
    output logic [7:0] lsr,
    output logic       rpt_valid,
    output logic       rpt_sel,
    output logic [7:0] rpt_byte
);
    logic     word_done;
    rx_word_t word;
    logic     err_new;

    rx_framer #(.OSR(OSR)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .rxd       (rxd),
        .lcr       (lcr),
        .word_done (word_done),
        .word      (word)
    );

    rx_lstat u_lstat (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word      (word),
        .rd_data   (rd_data),
        .rd_status (rd_status),
        .rx_data   (rx_data),
        .lsr       (lsr),
        .err_new   (err_new)
    );

    rx_report #(.DELTA_W(4)) u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_new   (err_new),
        .msr       (msr),
        .lsr       (lsr),
        .rpt_valid (rpt_valid),
        .rpt_sel   (rpt_sel),
        .rpt_byte  (rpt_byte)
    );

endmodule

// File: rtl/rx_line_chk.sv
module rx_line_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       word_done,
    input logic       rd_data,
    input logic       rd_status,
    input logic [7:0] rx_data,
    input logic [7:0] lsr,
    input logic       rpt_valid,
    input logic       rpt_sel
);
    // R3
    dr_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lsr[0]) |-> $past(word_done));

    // R4
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && lsr[0] && !rd_data) |=> ($stable(rx_data) && lsr[1]));

    // R8
    err_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[7] == (|lsr[4:2])) && (lsr[6:5] == 2'b00));

    // R7
    brk_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[4] |-> lsr[3]);

    // R9
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !word_done) |=> ((lsr[4:1] == 4'h0) && !lsr[7]));

    // R10
    rpt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_sel) |=> (rpt_valid && rpt_sel));

    // R10
    rpt_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_sel) |-> $past(rpt_valid && !rpt_sel));

endmodule

bind rx_line_top rx_line_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .rd_data   (rd_data),
    .rd_status (rd_status),
    .rx_data   (rx_data),
    .lsr       (lsr),
    .rpt_valid (rpt_valid),
    .rpt_sel   (rpt_sel)
);

// File: tb/test_rx_line_top.sv
module test_rx_line_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLKS   = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [5:0] lcr = 6'h03;
    logic       os_tick = 1'b0;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] msr = 8'h00;
    logic [7:0] rx_data, lsr, rpt_byte;
    logic       rpt_valid, rpt_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] sb_q[$];
    logic [7:0]  first_b;

    bit m_dr, m_oe, m_pe, m_fe, m_bi, m_er;
    logic [7:0] m_data;

    rx_line_top i_rx_line_top (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .lcr(lcr), .os_tick(os_tick),
        .rd_data(rd_data), .rd_status(rd_status), .msr(msr),
        .rx_data(rx_data), .lsr(lsr), .rpt_valid(rpt_valid),
        .rpt_sel(rpt_sel), .rpt_byte(rpt_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst_n) os_tick <= 1'b0;
        else        os_tick <= ~os_tick;
    end

    function automatic logic [7:0] model_lsr();
        return {m_er, 2'b00, m_bi, m_fe, m_pe, m_oe, m_dr};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for R10
    always @(negedge clk) begin
        if (rst_n && rpt_valid) begin
            if (!rpt_sel) first_b = rpt_byte;
            else begin
                n_cmp++;
                if (sb_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R10: actual %02h%02h expected no report", first_b, rpt_byte);
                end else begin
                    logic [15:0] e;
                    e = sb_q.pop_front();
                    if ({first_b, rpt_byte} !== e) begin
                        n_bad++;
                        $display("FAIL R10: actual %02h%02h expected %04h", first_b, rpt_byte, e);
                    end
                end
            end
        end
    end

    task automatic model_word(input logic [7:0] d, input bit pe, input bit fe, input bit bi);
        bit rpt;
        if (m_dr) begin
            rpt  = !m_oe;
            m_oe = 1'b1;
        end else begin
            rpt    = (pe && !m_pe) || (fe && !m_fe) || (bi && !m_bi);
            m_dr   = 1'b1;
            m_data = d;
            m_pe   = m_pe | pe;
            m_fe   = m_fe | fe;
            m_bi   = m_bi | bi;
            m_er   = m_er | pe | fe | bi;
        end
        if (rpt) sb_q.push_back({msr, model_lsr()});
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par,
                              input bit s1, input bit s2);
        int nb;
        logic [7:0] md;
        logic p;
        nb = 5 + int'(lcr[1:0]);
        md = d & ((8'h01 << nb) - 8'h01);
        if (lcr[5])      p = ~lcr[4];
        else if (lcr[4]) p = ^md;
        else             p = ~(^md);
        if (bad_par) p = ~p;
        model_word(md, lcr[3] && bad_par,
                   !s1 || (lcr[2] && nb > 5 && !s2), 1'b0);
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(md[i]);
        if (lcr[3]) drive_bit(p);
        drive_bit(s1);
        if (lcr[2]) drive_bit(s2);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic read_data();
        @(negedge clk) rd_data = 1'b1;
        @(negedge clk) rd_data = 1'b0;
        m_dr = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_status();
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
        {m_oe, m_pe, m_fe, m_bi, m_er} = '0;
        @(negedge clk);
    endtask

    task automatic chk_rx(input string tag);
        chk({tag, " data"}, rx_data, m_data);
        chk({tag, " lsr"}, lsr, model_lsr());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_data = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 data", rx_data, 8'h00);
        chk("R1 lsr", lsr, 8'h00);
        chk("R1 rpt", {7'd0, rpt_valid}, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 8-bit no parity
        lcr = 6'h03;
        send_frame(8'hA5, 0, 1, 1);
        chk_rx("R2 R3 8N1");
        read_data();
        chk("R3 read clears dr", lsr, 8'h00);

        // R5 7-bit even, good parity
        lcr = 6'h1A;
        send_frame(8'hB5, 0, 1, 1);
        chk_rx("R5 R2 7E1");
        read_data();

        // R5 R8 R10 8-bit odd, bad parity
        lcr = 6'h0B;
        send_frame(8'h3C, 1, 1, 1);
        chk_rx("R5 R8 odd bad");
        read_status();
        chk("R9 keeps dr", lsr, 8'h01);
        read_data();

        // R5 stick mark then space
        lcr = 6'h2B;
        send_frame(8'h81, 0, 1, 1);
        chk_rx("R5 mark good");
        read_data();
        send_frame(8'h81, 1, 1, 1);
        chk_rx("R5 mark bad");
        read_status();
        read_data();
        lcr = 6'h3B;
        send_frame(8'h42, 0, 1, 1);
        chk_rx("R5 space good");
        read_data();

        // R2 5-bit word masks upper bits
        lcr = 6'h00;
        send_frame(8'hFF, 0, 1, 1);
        chk_rx("R2 5-bit");
        read_data();

        // R6 framing on first stop
        lcr = 6'h03;
        send_frame(8'h55, 0, 0, 1);
        chk_rx("R6 first stop");
        read_status();
        read_data();

        // R6 second stop checked with two-stop setting
        lcr = 6'h07;
        send_frame(8'h5A, 0, 1, 0);
        chk_rx("R6 second stop");
        read_status();
        read_data();
        send_frame(8'h96, 0, 1, 1);
        chk_rx("R6 two stops good");
        read_data();

        // R4 overrun
        lcr = 6'h03;
        send_frame(8'h11, 0, 1, 1);
        send_frame(8'h22, 0, 1, 1);
        chk_rx("R4 overrun");
        read_status();
        read_data();

        // R7 break: long low, one word only
        model_word(8'h00, 0, 1, 1);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT_CLKS * 33) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLKS * 3) @(negedge clk);
        chk_rx("R7 break");
        read_status();
        read_data();
        chk("R9 R3 cleared", lsr, 8'h00);

        // R11 false start glitch
        @(negedge clk) rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLKS * 12) @(negedge clk);
        chk("R11 glitch lsr", lsr, 8'h00);

        // R10 modem delta rise
        msr = 8'h11;
        sb_q.push_back({8'h11, model_lsr()});
        repeat (10) @(negedge clk);
        msr = 8'h10;
        repeat (10) @(negedge clk);

        n_cmp++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: actual %0d pending expected 0", sb_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule